// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block is a memory-mapped slave that owns a 32 MB alias window. Every aligned 32-bit word in the window stands for one bit of a target memory region. An alias access becomes a single access on a master-side port. A read fetches the addressed unit and returns the selected bit. A write reads the unit, changes that one bit and writes the unit back at the same address and size.

The slave side uses a held request. The requester raises `s_req` with address, write flag, write data and size, and keeps them steady until `s_done` pulses. The master side raises `m_req` and holds it until the memory answers with a one-cycle `m_ack`. Only one transaction is in flight at a time. During the read-modify-write of an alias write, `m_lock` tells the interconnect that the read and the write belong together and that nothing may be placed between them.

Top module: `bitalias_bridge`

## Requirements
- R1: The alias offset is `s_addr - ALIAS_BASE`, reduced to its low 25 bits. The master address is `TGT_BASE | (offset >> 5)`. The defaults are `TGT_BASE` = 0x2000_0000 and `ALIAS_BASE` = 0x2200_0000.
- R2: Size codes on `s_size` and `m_size`:
  - 0 selects a byte.
  - 1 selects a halfword.
  - 2 selects a word.
  - 3 is issued on the master side as a word (2).

  A halfword master address has bit 0 cleared. A word master address has bits 1:0 cleared.
- R3: The selected bit is offset bits [4:2] within a byte, [5:2] within a halfword, or [6:2] within a word. The master data bus is little-endian: the byte at address a lies on bus bits 8*(a mod 4)+7 down to 8*(a mod 4).
- R4: An alias read returns 1 on `s_rdata` when the selected target bit is set and 0 when it is clear. Bits 31:1 of `s_rdata` are always zero.
- R5: An alias read issues exactly one master read and no master write.
- R6: An alias write issues one master read and then one master write, both to the same address and at the same size. The written data equals the read data with only the selected bit replaced.
- R7: On an alias write, the selected bit takes the value of `s_wdata` bit 0. Bits 31:1 of `s_wdata` have no effect.
- R8: During an alias write, `m_lock` is high throughout both master phases. During an alias read it is low.
- R9: `s_done` is a one-cycle pulse in the cycle after the final `m_ack` is sampled. `s_req` is sampled only while the bridge is idle, so a held request starts exactly one transaction.
- R10: While reset is asserted and directly after it, `m_req`, `m_lock` and `s_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_req | input | 1 | Slave request, held until s_done |
| s_addr | input | 32 | Alias address |
| s_we | input | 1 | 1 = alias write, 0 = alias read |
| s_wdata | input | 32 | Write data; only bit 0 is used |
| s_size | input | 2 | Access size code |
| s_done | output | 1 | One-cycle completion pulse |
| s_rdata | output | 32 | Read result, 0 or 1 |
| m_req | output | 1 | Master request, held until m_ack |
| m_addr | output | 32 | Target byte address |
| m_we | output | 1 | Master write flag |
| m_size | output | 2 | Master access size code |
| m_wdata | output | 32 | Master write data, little-endian lanes |
| m_lock | output | 1 | Keeps the read and write of a read-modify-write together |
| m_ack | input | 1 | One-cycle master acknowledge |
| m_rdata | input | 32 | Master read data, valid with m_ack |

## Verification
Two functions can meet in one cycle:
- the acknowledge that ends the master read phase, and the launch of the locked write phase that depends on the data just returned;
- the final acknowledge and the slave completion, while the requester is still holding `s_req`.

The bench provokes both with a memory model whose wait states rotate through zero, one and two. The zero-wait case puts the read acknowledge and the write launch on adjacent cycles, and a held request overlaps the completion cycle.

The bench judges the outcome from the master-side log of each transaction:
- how many reads and writes were issued, with their addresses, sizes and lock levels;
- the distance between the last acknowledge and `s_done`;
- a bit-exact comparison of the whole backing memory against a bench-side shadow.

// File: rtl/bb_pkg.sv
package bb_pkg;
  localparam int BB_AW = 32;
  localparam int BB_DW = 32;
  localparam int BB_IW = $clog2(BB_DW);

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_RSP} bb_state_e;

  // the reserved size code is carried out as a full word
  function automatic logic [1:0] norm_size(input logic [1:0] sz);
    return (sz == 2'd3) ? SZ_WORD : sz;
  endfunction

  // target byte address: base OR (window offset / 32), aligned to the size
  function automatic logic [BB_AW-1:0] tgt_addr(input logic [BB_AW-1:0] base,
                                                input logic [BB_AW-1:0] off,
                                                input int win_bits,
                                                input logic [1:0] sz);
    logic [BB_AW-1:0] a;
    logic [BB_AW-1:0] m;
    m = (BB_AW'(1) << win_bits) - BB_AW'(1);
    a = base | ((off & m) >> 5);
    if (sz == SZ_HALF) a[0] = 1'b0;
    else if (sz == SZ_WORD) a[1:0] = 2'b00;
    return a;
  endfunction

  // the lane position plus the in-unit index always equals offset[6:2]
  function automatic logic [BB_IW-1:0] lane_bit(input logic [BB_AW-1:0] off);
    return off[BB_IW+1:2];
  endfunction
endpackage

// File: rtl/bb_addr_map.sv
module bb_addr_map
  import bb_pkg::*;
#(
  parameter logic [BB_AW-1:0] TGT_BASE   = 32'h2000_0000,
  parameter logic [BB_AW-1:0] ALIAS_BASE = 32'h2200_0000,
  parameter int               WIN_BITS   = 25
) (
  input  logic [BB_AW-1:0] alias_addr,
  input  logic [1:0]       size_in,
  output logic [BB_AW-1:0] tgt,
  output logic [1:0]       size_out,
  output logic [BB_IW-1:0] bit_pos
);
  logic [BB_AW-1:0] off;
  logic [1:0]       sz_n;

  assign off      = alias_addr - ALIAS_BASE;
  assign sz_n     = norm_size(size_in);
  assign size_out = sz_n;
  assign tgt      = tgt_addr(TGT_BASE, off, WIN_BITS, sz_n);
  assign bit_pos  = lane_bit(off);
endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
  import bb_pkg::*;
(
  input  logic [BB_DW-1:0] rd_word,
  input  logic [BB_IW-1:0] bit_pos,
  input  logic             set_val,
  output logic [BB_DW-1:0] wr_word,
  output logic             sel_bit
);
  genvar gi;
  generate
    for (gi = 0; gi < BB_DW; gi++) begin : g_lane
      assign wr_word[gi] = (bit_pos == BB_IW'(gi)) ? set_val : rd_word[gi];
    end
  endgenerate

  assign sel_bit = rd_word[bit_pos];
endmodule

// File: rtl/bb_seq.sv
module bb_seq
  import bb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s_req,
  input  logic s_we,
  input  logic m_ack,
  output logic cap_en,
  output logic rd_ack,
  output logic op_is_wr,
  output logic m_req,
  output logic m_we,
  output logic m_lock,
  output logic s_done
);
  bb_state_e st_q, st_d;
  logic      wr_q;

  always_comb begin
    st_d   = st_q;
    cap_en = 1'b0;
    rd_ack = 1'b0;
    m_req  = 1'b0;
    m_we   = 1'b0;
    m_lock = 1'b0;
    s_done = 1'b0;
    case (st_q)
      ST_IDLE: if (s_req) begin
        cap_en = 1'b1;
        st_d   = ST_RD;
      end
      ST_RD: begin
        m_req  = 1'b1;
        m_lock = wr_q;
        if (m_ack) begin
          rd_ack = 1'b1;
          st_d   = wr_q ? ST_WR : ST_RSP;
        end
      end
      ST_WR: begin
        m_req  = 1'b1;
        m_we   = 1'b1;
        m_lock = 1'b1;
        if (m_ack) st_d = ST_RSP;
      end
      default: begin
        s_done = 1'b1;
        st_d   = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      wr_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cap_en) wr_q <= s_we;
    end
  end

  assign op_is_wr = wr_q;
endmodule

// File: rtl/bitalias_bridge.sv
module bitalias_bridge
  import bb_pkg::*;
#(
  parameter logic [BB_AW-1:0] TGT_BASE   = 32'h2000_0000,
  parameter logic [BB_AW-1:0] ALIAS_BASE = 32'h2200_0000,
  parameter int               WIN_BITS   = 25
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_req,
  input  logic [BB_AW-1:0] s_addr,
  input  logic             s_we,
  input  logic [BB_DW-1:0] s_wdata,
  input  logic [1:0]       s_size,
  output logic             s_done,
  output logic [BB_DW-1:0] s_rdata,
  output logic             m_req,
  output logic [BB_AW-1:0] m_addr,
  output logic             m_we,
  output logic [1:0]       m_size,
  output logic [BB_DW-1:0] m_wdata,
  output logic             m_lock,
  input  logic             m_ack,
  input  logic [BB_DW-1:0] m_rdata
);
  logic [BB_AW-1:0] cap_addr;
  logic [1:0]       cap_size;
  logic             cap_val;
  logic [BB_DW-1:0] rd_q;
  logic             cap_en;
  logic             rd_ack;
  logic             op_is_wr;
  logic [BB_IW-1:0] bit_pos;
  logic             sel_bit;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^s_wdata[BB_DW-1:1];

  bb_seq u_seq (
    .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .m_ack(m_ack),
    .cap_en(cap_en), .rd_ack(rd_ack), .op_is_wr(op_is_wr),
    .m_req(m_req), .m_we(m_we), .m_lock(m_lock), .s_done(s_done)
  );

  bb_addr_map #(.TGT_BASE(TGT_BASE), .ALIAS_BASE(ALIAS_BASE), .WIN_BITS(WIN_BITS)) u_map (
    .alias_addr(cap_addr), .size_in(cap_size),
    .tgt(m_addr), .size_out(m_size), .bit_pos(bit_pos)
  );

  bb_bit_merge u_merge (
    .rd_word(rd_q), .bit_pos(bit_pos), .set_val(cap_val),
    .wr_word(m_wdata), .sel_bit(sel_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_addr <= '0;
      cap_size <= SZ_BYTE;
      cap_val  <= 1'b0;
      rd_q     <= '0;
    end else begin
      if (cap_en) begin
        cap_addr <= s_addr;
        cap_size <= s_size;
        cap_val  <= s_wdata[0];
      end
      if (rd_ack) rd_q <= m_rdata;
    end
  end

  assign s_rdata = {{(BB_DW-1){1'b0}}, sel_bit};
endmodule

// File: rtl/bb_checker.sv
module bb_checker
  import bb_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             s_done,
  input logic [BB_DW-1:0] s_rdata,
  input logic             m_req,
  input logic             m_we,
  input logic             m_lock,
  input logic [BB_AW-1:0] m_addr,
  input logic [1:0]       m_size,
  input logic [BB_DW-1:0] m_rdata,
  input logic [BB_DW-1:0] m_wdata,
  input logic             op_is_wr,
  input logic             rd_ack,
  input logic [BB_IW-1:0] bit_pos,
  input logic [BB_DW-1:0] rd_q
);
  AST_READ_NO_MWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_we) |-> op_is_wr);                                      // R5
  AST_LOCK_RMW: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && op_is_wr) |=> (m_req && m_we && m_lock));                // R8
  AST_LOCK_READ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !op_is_wr) |-> !m_lock);                                  // R8
  AST_SAME_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && op_is_wr) |=> (m_addr == $past(m_addr) && m_size == $past(m_size))); // R6
  AST_ONE_BIT_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_we) |-> ($countones(m_wdata ^ rd_q) <= 1));             // R6
  AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_size == SZ_HALF) |-> !m_addr[0]);                       // R2
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_size == SZ_WORD) |-> (m_addr[1:0] == 2'b00));           // R2
  AST_READ_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !op_is_wr) |=> (s_done && s_rdata == (($past(m_rdata) >> $past(bit_pos)) & BB_DW'(1)))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    s_done |=> !s_done);                                                // R9
endmodule

bind bitalias_bridge bb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .s_done(s_done), .s_rdata(s_rdata),
  .m_req(m_req), .m_we(m_we), .m_lock(m_lock), .m_addr(m_addr), .m_size(m_size),
  .m_rdata(m_rdata), .m_wdata(m_wdata), .op_is_wr(op_is_wr), .rd_ack(rd_ack),
  .bit_pos(bit_pos), .rd_q(rd_q)
);

// File: tb/tb_bitalias_bridge.sv
module tb_bitalias_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_req = 1'b0;
  logic [31:0] s_addr = '0;
  logic        s_we = 1'b0;
  logic [31:0] s_wdata = '0;
  logic [1:0]  s_size = '0;
  logic        s_done;
  logic [31:0] s_rdata;
  logic        m_req;
  logic [31:0] m_addr;
  logic        m_we;
  logic [1:0]  m_size;
  logic [31:0] m_wdata;
  logic        m_lock;
  logic        m_ack = 1'b0;
  logic [31:0] m_rdata = '0;

  bitalias_bridge dut (.*);

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // backing memory (16 bytes, low address bits) and its expected image
  logic [7:0]   mem [16];
  logic [127:0] shadow;
  int lat = 0;
  int wcnt = 0;
  int n_rd, n_wr, ack_cyc;
  logic [31:0] rd_addr, wr_addr;
  logic [1:0]  rd_size, wr_size;
  logic        rd_lock, wr_lock;

  always @(negedge clk) begin
    if (m_ack) m_ack = 1'b0;
    else if (rst_n && m_req) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0;
        m_ack = 1'b1;
        ack_cyc = cyc;
        if (m_we) begin
          n_wr++; wr_addr = m_addr; wr_size = m_size; wr_lock = m_lock;
          for (int i = 0; i < 4; i++) begin
            bit en;
            case (m_size)
              2'd0: en = (i == int'(m_addr[1:0]));
              2'd1: en = ((i / 2) == int'(m_addr[1]));
              default: en = 1'b1;
            endcase
            if (en) mem[{m_addr[3:2], 2'(i)}] = m_wdata[8*i +: 8];
          end
        end else begin
          n_rd++; rd_addr = m_addr; rd_size = m_size; rd_lock = m_lock;
          for (int i = 0; i < 4; i++) m_rdata[8*i +: 8] = mem[{m_addr[3:2], 2'(i)}];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] a, input logic we, input logic [31:0] wd,
                        input logic [1:0] sz, output logic [31:0] rd, output int dcyc);
    @(negedge clk);
    n_rd = 0; n_wr = 0;
    s_addr = a; s_we = we; s_wdata = wd; s_size = sz; s_req = 1'b1;
    for (int t = 0; t < 50; t++) begin
      @(negedge clk);
      if (s_done) break;
    end
    rd = s_rdata; dcyc = cyc;
    s_req = 1'b0;
  endtask

  function automatic logic [31:0] exp_addr(input int k, input logic [1:0] sz);
    int unit;
    unit = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    return 32'h2000_0000 + 32'(((k / 8) / unit) * unit);
  endfunction

  function automatic bit mem_matches();
    for (int b = 0; b < 16; b++)
      if (mem[b] != shadow[8*b +: 8]) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int dcyc;
    for (int b = 0; b < 16; b++) begin
      mem[b] = 8'(b * 29 + 7);
      shadow[8*b +: 8] = 8'(b * 29 + 7);
    end
    repeat (3) @(negedge clk);
    chk(!m_req && !m_lock && !s_done, "R10 reset quiet", {m_req, m_lock, s_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!m_req && !m_lock && !s_done, "R10 after reset", {m_req, m_lock, s_done}, 0);

    for (int sz = 0; sz < 3; sz++) begin
      for (int k = 0; k < 128; k++) begin
        logic [31:0] al;
        logic        v;
        lat = (k + sz) % 3;
        al = 32'h2200_0000 + 32'(k * 4);
        // alias read
        access(al, 1'b0, 32'hFFFF_FFFE, 2'(sz), rd, dcyc);
        chk(rd == {31'b0, shadow[k]}, "R4 R3 read bit", rd, shadow[k]);
        chk(n_rd == 1 && n_wr == 0, "R5 read phases", n_rd * 10 + n_wr, 10);
        chk(rd_addr == exp_addr(k, 2'(sz)), "R1 R2 read address", rd_addr, exp_addr(k, 2'(sz)));
        chk(rd_size == 2'(sz) && !rd_lock, "R2 R8 read size/lock", {rd_size, rd_lock}, {2'(sz), 1'b0});
        chk(dcyc == ack_cyc + 1, "R9 done timing", dcyc - ack_cyc, 1);
        // alias write, upper data bits scrambled
        v = 1'(k ^ sz ^ (k >> 2)) ^ shadow[k] ^ 1'(k >> 4);
        shadow[k] = v;
        access(al, 1'b1, {31'(k * 32'h9E37_79B1), v}, 2'(sz), rd, dcyc);
        chk(n_rd == 1 && n_wr == 1, "R6 rmw phases", n_rd * 10 + n_wr, 11);
        chk(wr_addr == rd_addr && wr_addr == exp_addr(k, 2'(sz)) && wr_size == 2'(sz),
            "R6 R1 rmw target", wr_addr, exp_addr(k, 2'(sz)));
        chk(rd_lock && wr_lock, "R8 lock held", {rd_lock, wr_lock}, 2'b11);
        chk(mem_matches(), "R6 R7 memory image", 0, 1);
        chk(dcyc == ack_cyc + 1, "R9 done timing wr", dcyc - ack_cyc, 1);
      end
    end

    // reserved size code runs as a word
    lat = 0;
    access(32'h2200_0000 + 32'd20, 1'b0, 32'h0, 2'd3, rd, dcyc);
    chk(rd_size == 2'd2 && rd_addr == 32'h2000_0000, "R2 size 3 as word", rd_size, 2);
    chk(rd == {31'b0, shadow[5]}, "R4 size 3 read", rd, shadow[5]);

    // top of the window, byte access
    access(32'h23FF_FFFC, 1'b0, 32'h0, 2'd0, rd, dcyc);
    chk(rd_addr == 32'h200F_FFFF, "R1 window top address", rd_addr, 32'h200F_FFFF);
    chk(rd == {31'b0, shadow[127]}, "R3 window top bit", rd, shadow[127]);

    // write with bit 0 clear and every upper bit set
    shadow[127] = 1'b0;
    access(32'h23FF_FFFC, 1'b1, 32'hFFFF_FFFE, 2'd0, rd, dcyc);
    chk(mem_matches(), "R7 upper data ignored", mem[15], shadow[127:120]);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule